// File: doc/BRIEF.md
# Serial Control Word Loader

This block is the configuration port of a frequency synthesizer. A host writes 19-bit words over three wires: a serial clock, a data line and a load strobe. While the load strobe is low, each rising edge of the serial clock pushes one data bit into a shift register. The most significant bit is sent first, and the final bit of every word is a routing bit.

When the load strobe rises, the routing bit decides where the word goes. A routing bit of 1 sends it to the reference register. That register holds the reference divide value and four mode flags: prescaler modulus, comparator polarity, monitor-output select and charge-pump current. A routing bit of 0 sends it to the counter register, which holds the swallow count and the main count. Each register pulses its own one-cycle update strobe so that downstream counters can reload on the same clock.

A divide value below three is forbidden. Such a value is still latched, but it raises a sticky error flag. The flag stays set until the next load that carries a legal value. All serial inputs are sampled on the system clock, and the host must hold each serial clock level for at least one system clock cycle.

Top module: `serial_word_loader`

## Requirements
- R1: After reset, every latched field, both update strobes and the error flag are 0.
- R2: While the load strobe is low, each rising serial clock edge (seen on the system clock) shifts in one data bit. Bits are sent MSB first and the last bit sent is the routing bit, at shift position 0.
- R3: On a rising load strobe with routing bit 1, the reference divide value is taken from positions 14..1 (position 1 is its LSB). Prescaler select comes from position 15, polarity from 16, monitor select from 17 and pump current from 18. The counter fields keep their values.
- R4: On a rising load strobe with routing bit 0, the swallow value is taken from positions 7..1 and the main value from positions 18..8 (LSB at the lower position). The reference fields keep their values.
- R5: Serial clock edges that arrive while the load strobe is high do not change the shift register. A later load strobe latches the earlier word again.
- R6: A reference divide value below 3 in a reference load, or a main value below 3 in a counter load, is still latched and sets the error flag in the same cycle the fields update.
- R7: The error flag stays set until a load carrying a legal value; that load clears it. The load may be of either kind.
- R8: The matching update strobe is high for exactly one cycle, in the cycle the new fields first appear. The two strobes are never high together, and holding the load strobe high produces no second pulse.
- R9: If more than 19 bits are shifted in before a load, only the last 19 bits form the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock, sampled on clk |
| ser_dat | input | 1 | Serial data bit |
| ser_le | input | 1 | Load strobe; low while shifting |
| ref_div | output | 14 | Latched reference divide value |
| pre_sel | output | 1 | Latched prescaler modulus select |
| phase_inv | output | 1 | Latched comparator polarity |
| mon_sel | output | 1 | Latched monitor-output select |
| cp_hi | output | 1 | Latched charge-pump current select |
| ref_load | output | 1 | One-cycle pulse on a reference update |
| swal_cnt | output | 7 | Latched swallow value |
| main_div | output | 11 | Latched main counter value |
| cnt_load | output | 1 | One-cycle pulse on a counter update |
| div_err | output | 1 | Sticky flag for a forbidden divide value |

## Verification
The bench sweeps reference and main values across the forbidden boundary: 0, 1 and 2 must be flagged, and 3 must not. A design that compared against the wrong limit, or that refused to latch a flagged value, would disagree with the arithmetic model at exactly those points. The bench interleaves reference and counter loads with varied flag patterns. A swapped routing bit or a field taken one position off would corrupt the other register or scramble bit patterns that are not symmetric. The bench also clocks bits while the load strobe is high, over-long frames and a held load strobe. These expose a shifter that ignores the strobe, a shifter that keeps stale leading bits, and a level-triggered load that pulses repeatedly.

// File: rtl/serial_word_loader.sv
module serial_word_loader #(
  parameter int REF_W   = 14,
  parameter int SWL_W   = 7,
  parameter int MAIN_W  = 11,
  parameter int MIN_DIV = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_le,
  output logic [REF_W-1:0]  ref_div,
  output logic              pre_sel,
  output logic              phase_inv,
  output logic              mon_sel,
  output logic              cp_hi,
  output logic              ref_load,
  output logic [SWL_W-1:0]  swal_cnt,
  output logic [MAIN_W-1:0] main_div,
  output logic              cnt_load,
  output logic              div_err
);
  localparam int FRAME_W = REF_W + 5;
  localparam logic [REF_W-1:0]  REF_MIN  = REF_W'(MIN_DIV);
  localparam logic [MAIN_W-1:0] MAIN_MIN = MAIN_W'(MIN_DIV);

  logic               sclk_q, le_q;
  logic [FRAME_W-1:0] sr;

  wire shift_en = ser_clk & ~sclk_q & ~ser_le;
  wire load_en  = ser_le & ~le_q;
  wire to_ref   = sr[0];

  wire [REF_W-1:0]  r_new = sr[REF_W:1];
  wire [SWL_W-1:0]  a_new = sr[SWL_W:1];
  wire [MAIN_W-1:0] n_new = sr[FRAME_W-1 -: MAIN_W];
  wire              bad   = to_ref ? (r_new < REF_MIN) : (n_new < MAIN_MIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      le_q   <= 1'b0;
      sr     <= '0;
    end else begin
      sclk_q <= ser_clk;
      le_q   <= ser_le;
      if (shift_en) sr <= {sr[FRAME_W-2:0], ser_dat};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_div   <= '0;
      pre_sel   <= 1'b0;
      phase_inv <= 1'b0;
      mon_sel   <= 1'b0;
      cp_hi     <= 1'b0;
      swal_cnt  <= '0;
      main_div  <= '0;
      ref_load  <= 1'b0;
      cnt_load  <= 1'b0;
      div_err   <= 1'b0;
    end else begin
      ref_load <= load_en & to_ref;
      cnt_load <= load_en & ~to_ref;
      if (load_en) begin
        div_err <= bad;
        if (to_ref) begin
          ref_div   <= r_new;
          pre_sel   <= sr[REF_W+1];
          phase_inv <= sr[REF_W+2];
          mon_sel   <= sr[REF_W+3];
          cp_hi     <= sr[REF_W+4];
        end else begin
          swal_cnt <= a_new;
          main_div <= n_new;
        end
      end
    end
  end

  // R8
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ref_load && cnt_load));
  // R8
  strobe_from_le_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_load || cnt_load) |-> $past(ser_le));
  // R5
  hold_while_le_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_le |=> $stable(sr));
  // R4
  ref_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_load |-> $stable(ref_div) && $stable(cp_hi) && $stable(pre_sel));
  // R3
  cnt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_load |-> $stable(main_div) && $stable(swal_cnt));
  // R6
  bad_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_load && main_div < MAIN_MIN) |-> div_err);
  // R7
  err_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ref_load || cnt_load) |-> $stable(div_err));
endmodule

// File: tb/serial_word_loader_tb.sv
module serial_word_loader_tb;
  logic clk = 0, rst_n = 0, ser_clk = 0, ser_dat = 0, ser_le = 0;
  logic [13:0] ref_div; logic pre_sel, phase_inv, mon_sel, cp_hi, ref_load;
  logic [6:0] swal_cnt; logic [10:0] main_div; logic cnt_load, div_err;
  int total = 0, bad = 0;
  logic [13:0] e_r = 0; logic [3:0] e_f = 0; logic [6:0] e_a = 0;
  logic [10:0] e_n = 0; logic e_err = 0;

  always #4 clk = ~clk;

  serial_word_loader u_dut (.clk, .rst_n, .ser_clk, .ser_dat, .ser_le,
    .ref_div, .pre_sel, .phase_inv, .mon_sel, .cp_hi, .ref_load,
    .swal_cnt, .main_div, .cnt_load, .div_err);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(logic b);
    @(negedge clk); ser_dat = b; ser_clk = 1;
    @(negedge clk); ser_clk = 0;
  endtask

  task automatic send_word(logic [18:0] w);
    for (int i = 18; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic model(logic [18:0] w);
    if (w[0]) begin
      e_r = w[14:1]; e_f = w[18:15]; e_err = (w[14:1] < 3);
    end else begin
      e_a = w[7:1]; e_n = w[18:8]; e_err = (w[18:8] < 3);
    end
  endtask

  task automatic check_fields(string req);
    chk({req, " ref_div"}, ref_div, e_r);
    chk({req, " flags"}, {cp_hi, mon_sel, phase_inv, pre_sel}, e_f);
    chk({req, " swal"}, swal_cnt, e_a);
    chk({req, " main"}, main_div, e_n);
    chk({req, " err"}, div_err, e_err);
  endtask

  task automatic load(logic [18:0] w, string req);
    @(negedge clk); ser_le = 1;
    @(negedge clk); #1;
    model(w);
    chk({req, " R8 strobe"}, {ref_load, cnt_load}, {w[0], ~w[0]});
    check_fields(req);
    @(negedge clk); #1;
    chk({req, " R8 pulse end"}, {ref_load, cnt_load}, 2'b00);
    ser_le = 0;
  endtask

  function automatic logic [18:0] ref_word(logic [13:0] r, logic [3:0] f);
    return {f, r, 1'b1};
  endfunction
  function automatic logic [18:0] cnt_word(logic [10:0] n, logic [6:0] a);
    return {n, a, 1'b0};
  endfunction

  initial begin
    #1600000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 strobes", {ref_load, cnt_load}, 2'b00);
    check_fields("R1");
    rst_n = 1;
    // R2 R3 R6 reference sweep across boundary and varied flags
    for (int r = 0; r < 48; r++) begin
      logic [18:0] w = ref_word(14'(r * 341 % 16384 < 3 ? r : r * 341 % 16384), 4'(r));
      send_word(w); load(w, "R3 R2 R6");
    end
    for (int r = 0; r < 6; r++) begin
      logic [18:0] w = ref_word(14'(r), 4'(~r));
      send_word(w); load(w, "R6 ref boundary");
    end
    send_word(ref_word(14'h3fff, 4'b1010)); load(ref_word(14'h3fff, 4'b1010), "R3 max");
    // R4 R6 R7 counter sweep, interleaved with reference loads
    for (int n = 0; n < 40; n++) begin
      logic [18:0] w = cnt_word(11'(n < 8 ? n : n * 53), 7'(n * 37));
      send_word(w); load(w, "R4 R6 R7");
      if (n % 5 == 0) begin
        w = ref_word(14'(n + 3), 4'(n));
        send_word(w); load(w, "R7 clear by ref");
      end
    end
    send_word(cnt_word(11'h7ff, 7'h7f)); load(cnt_word(11'h7ff, 7'h7f), "R4 max");
    // R7 error sticky until legal load
    send_word(cnt_word(11'd1, 7'd5)); load(cnt_word(11'd1, 7'd5), "R7 set");
    repeat (10) @(negedge clk);
    #1 chk("R7 sticky", div_err, 1'b1);
    send_word(ref_word(14'd3, 4'd0)); load(ref_word(14'd3, 4'd0), "R7 clear");
    // R5 bits while load strobe high are ignored
    send_word(cnt_word(11'd100, 7'd9));
    @(negedge clk); ser_le = 1;
    send_word(ref_word(14'd2, 4'hf));
    @(negedge clk); ser_le = 0;
    load(cnt_word(11'd100, 7'd9), "R5 reload");
    // R8 held strobe gives one pulse
    begin
      int pulses = 0;
      send_word(ref_word(14'd777, 4'b0110));
      @(negedge clk); ser_le = 1;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk); #1;
        if (ref_load || cnt_load) pulses++;
      end
      ser_le = 0;
      model(ref_word(14'd777, 4'b0110));
      chk("R8 single pulse", pulses, 1);
      check_fields("R8 held");
    end
    // R9 long frame keeps last 19 bits
    for (int k = 1; k < 8; k++) begin
      logic [18:0] w = (k % 2) ? ref_word(14'(k * 1000), 4'(k)) : cnt_word(11'(k * 200), 7'(k));
      for (int j = 0; j < k; j++) send_bit(j % 2 == 0);
      send_word(w); load(w, "R9");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule